// File: doc/BRIEF.md
# Clock-Synchronous Serial Transceiver

This block moves one byte at a time over a three-wire synchronous link: serial data out, serial data in and a shared serial clock. It sends and receives in the same frame. A parallel byte is handed in with a valid/ready handshake, and the received byte comes back with a one-cycle valid pulse. The block can be the clock master. It then derives the bit clock from the system clock through a programmable divider and drives a burst on the clock pin only while a frame is in progress. It can also work from an external clock, either as a slave or as a master whose clock output is switched off, and then shifts once per bit on the edges it sees on the clock input.

Each frame can carry just the data bits or be wrapped with a start bit and a stop bit. The clock rests high between frames. Two options change the clock timing. One moves the master clock by half a bit period relative to the data. The other swaps the sampling edge from rising to falling. The configuration inputs are expected to stay stable while a frame is in flight.

Top module: `sync_serial_xcvr`

## Requirements
- R1: After reset and whenever no frame is active, txReady is 1, sclkOut is 1, serOut is 1, rxValid is 0, and sclkOe equals cfgMaster AND cfgClkOutEn.
- R2: A byte is accepted on a clock edge where txValid and txReady are both 1. txReady then stays 0 until the frame has finished. No frame starts, and no clock edge is acted upon, without an accepted byte.
- R3: With the internal clock (cfgMaster=1, cfgClkOutEn=1), each frame puts exactly N falling edges on sclkOut. N is DATA_BITS (8), or DATA_BITS+2 (10) when cfgFraming=1.
- R4: The frame on serOut is LSB first. With cfgFraming=1 it is a 0 start bit, then the data bits, then a 1 stop bit.
- R5: With the internal clock, one half-bit lasts cfgDivider system clocks, and a value of 0 acts as 1. txReady is therefore low for exactly 2*N*max(cfgDivider,1) cycles per frame.
- R6: With the internal clock, sclkOut is low in the first half of each bit and high in the second half when cfgInvert equals cfgDelay, and the opposite otherwise. Receive data is sampled at the mid-bit edge.
- R7: Setting cfgDelay moves the internal clock output by half a bit period relative to serOut, without changing the number of clock cycles.
- R8: With the external clock, serIn is sampled on rising sclkIn edges when cfgInvert=0 and on falling edges when cfgInvert=1. serOut advances on the opposite edge, and only after a sample.
- R9: The external clock is used when cfgMaster=0 or cfgClkOutEn=0. In that mode sclkOe is 0 and sclkOut stays 1. sclkIn passes through a two-flop synchronizer. Edges on sclkIn while the block is idle are ignored.
- R10: After the final sample of a frame, rxValid is 1 for exactly one cycle. During that cycle rxData holds the received data bits, with the first bit received in bit 0.
- R11: rxFrameErr is 1 only together with rxValid, and only when cfgFraming=1 and the stop bit was sampled as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgMaster | input | 1 | 1 selects clock master |
| cfgClkOutEn | input | 1 | 1 enables the clock output in master mode |
| cfgFraming | input | 1 | 1 adds start and stop bits |
| cfgDelay | input | 1 | 1 shifts the master clock by half a bit |
| cfgInvert | input | 1 | 1 moves sampling to the falling edge |
| cfgDivider | input | DIV_W | Half-bit length in system clocks (0 acts as 1) |
| txData | input | DATA_BITS | Byte to send |
| txValid | input | 1 | Transmit byte offered |
| txReady | output | 1 | Block idle, ready to accept a byte |
| serIn | input | 1 | Serial receive data |
| serOut | output | 1 | Serial transmit data |
| sclkIn | input | 1 | External serial clock |
| sclkOut | output | 1 | Serial clock output |
| sclkOe | output | 1 | Serial clock output enable |
| rxData | output | DATA_BITS | Received byte, valid with rxValid |
| rxValid | output | 1 | One-cycle receive strobe |
| rxFrameErr | output | 1 | Stop bit sampled low, valid with rxValid |

## Verification
The bound checker watches, on every cycle, that the line rests at mark level while idle, that txReady drops after an accept, and that rxValid is a single-cycle pulse that qualifies the framing error. It also checks that the external-clock modes keep the clock pin quiet. It counts the falling clock edges of each master frame against the framed or unframed bit count. The bench's scenarios cover the rest. They check the bit order on the wire, the half-bit length for each divider value including zero, and the first-half clock level under each combination of delay and inversion. They check which sclkIn edge samples and which one shifts, that idle clock edges are ignored, and the received byte and stop-bit error for a driven slave frame.

// File: rtl/ssx_pkg.sv
package ssx_pkg;
  // strobes sent from control to datapath, one cycle each
  typedef struct packed {
    logic load;    // capture a new transmit byte
    logic sample;  // shift serIn into the receive register
    logic shift;   // advance the transmit register
    logic last;    // the sample is the final one of the frame
    logic active;  // a frame is in progress
  } ssx_strobe_t;
endpackage

// File: rtl/ssx_edge_sync.sv
module ssx_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic pinIn,
  output logic rise,
  output logic fall
);
  localparam int PIPE_W = SYNC_STAGES + 1;

  logic [PIPE_W-1:0] pipeQ;

  // rests at mark level so leaving reset never looks like an edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipeQ <= '1;
    else       pipeQ <= {pipeQ[PIPE_W-2:0], pinIn};
  end

  assign rise = pipeQ[PIPE_W-2] & ~pipeQ[PIPE_W-1];
  assign fall = ~pipeQ[PIPE_W-2] & pipeQ[PIPE_W-1];
endmodule

// File: rtl/ssx_ctrl.sv
module ssx_ctrl
  import ssx_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int DIV_W     = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgMaster,
  input  logic             cfgClkOutEn,
  input  logic             cfgFraming,
  input  logic             cfgDelay,
  input  logic             cfgInvert,
  input  logic [DIV_W-1:0] cfgDivider,
  input  logic             txValid,
  output logic             txReady,
  input  logic             sclkIn,
  output logic             sclkOut,
  output logic             sclkOe,
  output ssx_strobe_t      strb
);
  localparam int MAX_BITS = DATA_BITS + 2;
  localparam int CNT_W    = $clog2(2 * MAX_BITS + 1);
  localparam logic [CNT_W-1:0] FRAMED_BITS = CNT_W'(MAX_BITS);
  localparam logic [CNT_W-1:0] PLAIN_BITS  = CNT_W'(DATA_BITS);

  logic             busyQ;
  logic [DIV_W-1:0] halfCntQ;
  logic [CNT_W-1:0] phaseQ;     // half-bit index (internal) or sample count (external)
  logic             sampledQ;   // external mode: a sample is waiting for its shift

  logic             intClk;
  logic [CNT_W-1:0] nBits, lastHalf, lastSampleHalf;
  logic [DIV_W-1:0] divEff;
  logic             accept, halfEnd;
  logic             sampleInt, shiftInt, lastInt, endInt;
  logic             extRise, extFall, sampleEdge, driveEdge;
  logic             sampleExt, shiftExt, lastExt;

  ssx_edge_sync #(.SYNC_STAGES(2)) sync_i (
    .clk  (clk),
    .rstN (rstN),
    .pinIn(sclkIn),
    .rise (extRise),
    .fall (extFall)
  );

  assign intClk         = cfgMaster & cfgClkOutEn;
  assign nBits          = cfgFraming ? FRAMED_BITS : PLAIN_BITS;
  assign lastHalf       = (nBits << 1) - CNT_W'(1);
  assign lastSampleHalf = (nBits << 1) - CNT_W'(2);
  assign divEff         = (cfgDivider == '0) ? DIV_W'(1) : cfgDivider;
  assign accept         = txValid & ~busyQ;

  // internal clock: even half-bits end with a sample, odd ones with a shift
  assign halfEnd   = busyQ & intClk & (halfCntQ == divEff - DIV_W'(1));
  assign sampleInt = halfEnd & ~phaseQ[0];
  assign lastInt   = sampleInt & (phaseQ == lastSampleHalf);
  assign endInt    = halfEnd & (phaseQ == lastHalf);
  assign shiftInt  = halfEnd & phaseQ[0] & ~endInt;

  // external clock: sample edge, then the opposite edge advances the output
  assign sampleEdge = cfgInvert ? extFall : extRise;
  assign driveEdge  = cfgInvert ? extRise : extFall;
  assign sampleExt  = busyQ & ~intClk & sampleEdge;
  assign lastExt    = sampleExt & (phaseQ == nBits - CNT_W'(1));
  assign shiftExt   = busyQ & ~intClk & driveEdge & sampledQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ    <= 1'b0;
      halfCntQ <= '0;
      phaseQ   <= '0;
      sampledQ <= 1'b0;
    end else if (accept) begin
      busyQ    <= 1'b1;
      halfCntQ <= '0;
      phaseQ   <= '0;
      sampledQ <= 1'b0;
    end else if (busyQ) begin
      if (intClk) begin
        if (halfEnd) begin
          halfCntQ <= '0;
          if (endInt) busyQ  <= 1'b0;
          else        phaseQ <= phaseQ + CNT_W'(1);
        end else begin
          halfCntQ <= halfCntQ + DIV_W'(1);
        end
      end else begin
        if (sampleExt) begin
          if (lastExt) busyQ <= 1'b0;
          else begin
            phaseQ   <= phaseQ + CNT_W'(1);
            sampledQ <= 1'b1;
          end
        end
        if (shiftExt) sampledQ <= 1'b0;
      end
    end
  end

  assign txReady = ~busyQ;
  assign sclkOe  = intClk;
  // first half of a bit is low unless exactly one of invert/delay is set
  assign sclkOut = (busyQ & intClk) ? (phaseQ[0] ^ cfgInvert ^ cfgDelay) : 1'b1;

  assign strb.load   = accept;
  assign strb.sample = sampleInt | sampleExt;
  assign strb.shift  = shiftInt | shiftExt;
  assign strb.last   = lastInt | lastExt;
  assign strb.active = busyQ;
endmodule

// File: rtl/ssx_datapath.sv
module ssx_datapath
  import ssx_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgFraming,
  input  ssx_strobe_t          strb,
  input  logic [DATA_BITS-1:0] txData,
  input  logic                 serIn,
  output logic                 serOut,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 rxValid,
  output logic                 rxFrameErr
);
  localparam int SR_W = DATA_BITS + 2;

  logic [SR_W-1:0] txSrQ, rxSrQ;
  logic            rxValidQ, rxErrQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSrQ <= '1;
    end else if (strb.load) begin
      txSrQ <= cfgFraming ? {1'b1, txData, 1'b0} : {2'b11, txData};
    end else if (strb.shift) begin
      txSrQ <= {1'b1, txSrQ[SR_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSrQ    <= '0;
      rxValidQ <= 1'b0;
      rxErrQ   <= 1'b0;
    end else begin
      if (strb.sample) rxSrQ <= {serIn, rxSrQ[SR_W-1:1]};
      rxValidQ <= strb.sample & strb.last;
      rxErrQ   <= strb.sample & strb.last & cfgFraming & ~serIn;
    end
  end

  assign serOut     = strb.active ? txSrQ[0] : 1'b1;
  assign rxData     = cfgFraming ? rxSrQ[SR_W-2:1] : rxSrQ[SR_W-1:2];
  assign rxValid    = rxValidQ;
  assign rxFrameErr = rxErrQ;
endmodule

// File: rtl/sync_serial_xcvr.sv
module sync_serial_xcvr
  import ssx_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int DIV_W     = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgMaster,
  input  logic                 cfgClkOutEn,
  input  logic                 cfgFraming,
  input  logic                 cfgDelay,
  input  logic                 cfgInvert,
  input  logic [DIV_W-1:0]     cfgDivider,
  input  logic [DATA_BITS-1:0] txData,
  input  logic                 txValid,
  output logic                 txReady,
  input  logic                 serIn,
  output logic                 serOut,
  input  logic                 sclkIn,
  output logic                 sclkOut,
  output logic                 sclkOe,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 rxValid,
  output logic                 rxFrameErr
);
  ssx_strobe_t strb;

  ssx_ctrl #(.DATA_BITS(DATA_BITS), .DIV_W(DIV_W)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .cfgMaster  (cfgMaster),
    .cfgClkOutEn(cfgClkOutEn),
    .cfgFraming (cfgFraming),
    .cfgDelay   (cfgDelay),
    .cfgInvert  (cfgInvert),
    .cfgDivider (cfgDivider),
    .txValid    (txValid),
    .txReady    (txReady),
    .sclkIn     (sclkIn),
    .sclkOut    (sclkOut),
    .sclkOe     (sclkOe),
    .strb       (strb)
  );

  ssx_datapath #(.DATA_BITS(DATA_BITS)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .cfgFraming(cfgFraming),
    .strb      (strb),
    .txData    (txData),
    .serIn     (serIn),
    .serOut    (serOut),
    .rxData    (rxData),
    .rxValid   (rxValid),
    .rxFrameErr(rxFrameErr)
  );
endmodule

// File: rtl/ssx_checker.sv
module ssx_checker #(
  parameter int DATA_BITS = 8
) (
  input logic clk,
  input logic rstN,
  input logic cfgFraming,
  input logic txValid,
  input logic txReady,
  input logic serOut,
  input logic sclkOut,
  input logic sclkOe,
  input logic rxValid,
  input logic rxFrameErr
);
  localparam int FC_W = $clog2(DATA_BITS + 3) + 1;

  logic            prevClkQ;
  logic [FC_W-1:0] fallCntQ;
  logic [FC_W-1:0] expFalls;

  assign expFalls = cfgFraming ? FC_W'(DATA_BITS + 2) : FC_W'(DATA_BITS);

  // falling edges on the clock pin since the last accepted byte
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevClkQ <= 1'b1;
      fallCntQ <= '0;
    end else begin
      prevClkQ <= sclkOut;
      if (txValid && txReady)       fallCntQ <= '0;
      else if (prevClkQ && !sclkOut) fallCntQ <= fallCntQ + FC_W'(1);
    end
  end

  assert_idle_mark_R1: assert property (@(posedge clk) disable iff (!rstN)
    txReady |-> (sclkOut && serOut));

  assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady) |=> !txReady);

  assert_burst_len_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(txReady) && sclkOe) |-> (fallCntQ == expFalls));

  assert_ext_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    !sclkOe |-> sclkOut);

  assert_rx_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  assert_err_qual_R11: assert property (@(posedge clk) disable iff (!rstN)
    rxFrameErr |-> rxValid);
endmodule

bind sync_serial_xcvr ssx_checker #(.DATA_BITS(DATA_BITS)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .cfgFraming(cfgFraming),
  .txValid   (txValid),
  .txReady   (txReady),
  .serOut    (serOut),
  .sclkOut   (sclkOut),
  .sclkOe    (sclkOe),
  .rxValid   (rxValid),
  .rxFrameErr(rxFrameErr)
);

// File: tb/sync_serial_xcvr_tb_top.sv
`timescale 1ns/100ps
module sync_serial_xcvr_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgMaster = 1'b1, cfgClkOutEn = 1'b1, cfgFraming = 1'b0;
  logic       cfgDelay = 1'b0, cfgInvert = 1'b0;
  logic [7:0] cfgDivider = 8'd2;
  logic [7:0] txData = 8'h00;
  logic       txValid = 1'b0;
  logic       txReady, serOut, sclkOut, sclkOe, rxValid, rxFrameErr;
  logic [7:0] rxData;
  logic       sclkIn = 1'b1;
  logic       serInDrv = 1'b1;
  logic       loopback = 1'b1;
  logic       serIn;

  int checks = 0, fails = 0;
  int rxCnt = 0, fallCnt = 0, busyCnt = 0;
  logic [7:0] gotData = 8'h00;
  logic       gotErr = 1'b0;
  logic       prevSclk = 1'b1;
  logic       finished = 1'b0;

  always #2.5 clk = ~clk;

  assign serIn = loopback ? serOut : serInDrv;

  sync_serial_xcvr #(.DATA_BITS(8), .DIV_W(8)) dut_i (
    .clk(clk), .rstN(rstN), .cfgMaster(cfgMaster), .cfgClkOutEn(cfgClkOutEn),
    .cfgFraming(cfgFraming), .cfgDelay(cfgDelay), .cfgInvert(cfgInvert),
    .cfgDivider(cfgDivider), .txData(txData), .txValid(txValid), .txReady(txReady),
    .serIn(serIn), .serOut(serOut), .sclkIn(sclkIn), .sclkOut(sclkOut), .sclkOe(sclkOe),
    .rxData(rxData), .rxValid(rxValid), .rxFrameErr(rxFrameErr)
  );

  // port monitor, sampled on the falling edge
  always @(negedge clk) begin
    if (rstN) begin
      if (rxValid) begin
        rxCnt   = rxCnt + 1;
        gotData = rxData;
        gotErr  = rxFrameErr;
      end
      if (prevSclk && !sclkOut) fallCnt = fallCnt + 1;
      if (!txReady) busyCnt = busyCnt + 1;
    end
    prevSclk = sclkOut;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  typedef struct packed {
    logic [7:0] d;
    logic       fr;
    logic       inv;
    logic       dly;
    logic [3:0] divider;
    logic [3:0] expCyc;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{d: 8'hA5, fr: 1'b0, inv: 1'b0, dly: 1'b0, divider: 4'd2, expCyc: 4'd8},
    '{d: 8'h3C, fr: 1'b1, inv: 1'b0, dly: 1'b0, divider: 4'd3, expCyc: 4'd10},
    '{d: 8'h01, fr: 1'b0, inv: 1'b1, dly: 1'b0, divider: 4'd1, expCyc: 4'd8},
    '{d: 8'h80, fr: 1'b1, inv: 1'b0, dly: 1'b1, divider: 4'd2, expCyc: 4'd10},
    '{d: 8'hFF, fr: 1'b1, inv: 1'b1, dly: 1'b1, divider: 4'd4, expCyc: 4'd10},
    '{d: 8'h5A, fr: 1'b0, inv: 1'b0, dly: 1'b0, divider: 4'd0, expCyc: 4'd8}
  };

  // internal clock, serOut looped back to serIn
  task automatic runMaster(input vec_t v);
    int d, n, rx0, f0, b0;
    logic [9:0] expBits, gotBits;
    d = (v.divider == 4'd0) ? 1 : int'(v.divider);
    n = v.fr ? 10 : 8;
    expBits = v.fr ? {1'b1, v.d, 1'b0} : {2'b11, v.d};
    gotBits = '1;
    @(posedge clk); #1;
    loopback = 1'b1; cfgMaster = 1'b1; cfgClkOutEn = 1'b1;
    cfgFraming = v.fr; cfgInvert = v.inv; cfgDelay = v.dly;
    cfgDivider = {4'd0, v.divider}; txData = v.d; txValid = 1'b1;
    rx0 = rxCnt; f0 = fallCnt; b0 = busyCnt;
    @(posedge clk); #1;
    txValid = 1'b0;
    for (int t = 0; t < 2 * n * d + 4; t++) begin
      @(negedge clk);
      if (t == 0) chk("R6/R7 first half-bit clock level", sclkOut, v.inv ^ v.dly);
      if (t >= d && ((t - d) % (2 * d)) == 0 && ((t - d) / (2 * d)) < n)
        gotBits[(t - d) / (2 * d)] = serOut;
    end
    chk("R4 serial bit order", gotBits, expBits);
    chk("R3 clock cycles per frame", fallCnt - f0, int'(v.expCyc));
    chk("R5 busy cycles", busyCnt - b0, 2 * n * d);
    chk("R10 one receive pulse", rxCnt - rx0, 1);
    chk("R10 received byte", gotData, v.d);
    chk("R11 no framing error", gotErr, 0);
  endtask

  // external clock driven by the bench
  task automatic runExt(input logic masterSel, input logic inv, input logic fr,
                        input logic [7:0] txB, input logic [7:0] rxB, input logic stopBit);
    int n, rx0;
    logic [9:0] inBits, expOut, gotBits;
    n = fr ? 10 : 8;
    inBits  = fr ? {stopBit, rxB, 1'b0} : {2'b11, rxB};
    expOut  = fr ? {1'b1, txB, 1'b0} : {2'b11, txB};
    gotBits = '1;
    @(posedge clk); #1;
    loopback = 1'b0; cfgMaster = masterSel; cfgClkOutEn = ~masterSel;
    cfgInvert = inv; cfgFraming = fr; cfgDelay = 1'b0;
    txData = txB; txValid = 1'b1; sclkIn = 1'b1;
    rx0 = rxCnt;
    @(posedge clk); #1;
    txValid = 1'b0;
    for (int k = 0; k < n; k++) begin
      if (!inv) begin
        sclkIn = 1'b0; serInDrv = inBits[k];
        waitCyc(6);
        gotBits[k] = serOut;
        if (k == 0) begin
          chk("R9 clock output disabled", sclkOe, 0);
          chk("R9 clock pin stays high", sclkOut, 1);
        end
        sclkIn = 1'b1;
        waitCyc(6);
      end else begin
        serInDrv = inBits[k];
        waitCyc(6);
        gotBits[k] = serOut;
        sclkIn = 1'b0;
        waitCyc(6);
        sclkIn = 1'b1;
        waitCyc(6);
      end
    end
    waitCyc(8);
    chk("R8 transmit bit per edge pair", gotBits, expOut);
    chk("R10 one receive pulse", rxCnt - rx0, 1);
    chk("R8 received byte", gotData, rxB);
    chk("R11 framing error flag", gotErr, fr & ~stopBit);
    chk("R2 ready after frame", txReady, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int rx0;
    waitCyc(4);
    chk("R1 ready in reset", txReady, 1);
    chk("R1 clock idle in reset", sclkOut, 1);
    rstN = 1'b1;
    waitCyc(3);
    chk("R1 ready after reset", txReady, 1);
    chk("R1 clock high", sclkOut, 1);
    chk("R1 data at mark", serOut, 1);
    chk("R1 no receive strobe", rxValid, 0);
    chk("R1 output enable follows mode", sclkOe, 1);

    for (int i = 0; i < NVEC; i++) runMaster(VECS[i]);

    // idle external edges are ignored
    loopback = 1'b0; cfgMaster = 1'b0; cfgInvert = 1'b0;
    rx0 = rxCnt;
    for (int i = 0; i < 10; i++) begin
      sclkIn = ~sclkIn;
      waitCyc(3);
    end
    sclkIn = 1'b1;
    waitCyc(4);
    chk("R9 idle edges give no receive", rxCnt - rx0, 0);
    chk("R2 still ready after idle edges", txReady, 1);
    chk("R9 data stays at mark", serOut, 1);

    runExt(1'b0, 1'b0, 1'b0, 8'hC3, 8'h96, 1'b1);
    runExt(1'b0, 1'b1, 1'b1, 8'h2D, 8'hE1, 1'b1);
    runExt(1'b1, 1'b0, 1'b1, 8'h71, 8'h4B, 1'b1);
    runExt(1'b1, 1'b1, 1'b0, 8'h0F, 8'hB8, 1'b1);
    // stop bit driven low
    runExt(1'b0, 1'b0, 1'b1, 8'h55, 8'h6E, 1'b0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule